// File: doc/BRIEF.md
# Halfword-Only Memory Access Bridge

This block sits between a 32-bit host access port and an on-chip memory that only accepts 16-bit transfers. Host word, halfword and byte reads and writes are turned into one or two halfword transactions in big-endian order. The more significant half of a word always lives at the lower address. A low-half read variant fetches only the second halfword of a word. A byte write is done as a read-modify-write of the halfword that contains it. A clear operation writes zero halfwords over a byte length, one halfword per cycle.

The host raises a request with an operation code, a byte address, write data and, for a clear, a byte length. The request is taken only while `busy_o` is low. `busy_o` stays high until a one-cycle `done_o` pulse. At that pulse `err_o` tells whether the request was rejected as misaligned, and `rdata_o` holds the read result. The memory is a synchronous 16-bit RAM with one cycle of read latency. Its byte address width is a parameter; the 64 KB configuration uses `AW = 16`.

Top module: `hwb_bridge`

## Requirements
- R1: A word read (op code 0) at byte address A returns the halfword at A in bits 31:16 and the halfword at A+2 in bits 15:0.
- R2: A word write (op code 4) at byte address A stores bits 31:16 at A in one cycle, then bits 15:0 at A+2 in the next cycle. Any two back-to-back memory writes target consecutive halfwords.
- R3: A byte read (op code 2) returns, zero-extended in bits 7:0, the upper byte of the aligned halfword when address bit 0 is 0, and the lower byte when it is 1.
- R4: A low-half read (op code 3) at byte address A returns the halfword at A+2, zero-extended to 32 bits.
- R5: A halfword read (op code 1) returns the halfword at an even address, zero-extended. A halfword write (op code 5) stores `wdata_i[15:0]` there.
- R6: A byte write (op code 6) reads the containing halfword and writes it back to the same halfword. `wdata_i[7:0]` replaces the upper byte when address bit 0 is 0 and the lower byte when it is 1, and the other byte is preserved.
- R7: A clear (op code 7) writes zero to floor(`len_i`/2) consecutive halfwords starting at the even address. A length of 0 or 1 writes nothing.
- R8: A misaligned request is rejected with `err_o` high at `done_o`, no memory write, and `rdata_o` equal to 0. Misaligned means: a word read, word write or low-half read with address bits 1:0 not 00, or a halfword read, halfword write or clear with address bit 0 set.
- R9: `busy_o` is high from the cycle after acceptance through the cycle of `done_o`. `done_o` lasts exactly one cycle. A request raised while busy is ignored, and the memory is not touched while idle.
- R10: Counting the accepting clock edge as 1, `done_o` appears after edge 4 for a word read, after edge 3 for halfword, byte and low-half reads and for word and byte writes, after edge 2 for a halfword write, after edge N+1 for a clear of N halfwords, and after edge 1 for a rejected request.
- R11: While reset is held and after its release, `busy_o`, `done_o` and `err_o` are 0 and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, taken when `busy_o` is low |
| op_i | input | 3 | Operation code (see R1 to R7) |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| len_i | input | AW+1 | Clear length in bytes |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Misalignment reject, valid with `done_o` |
| rdata_o | output | 32 | Read result, valid from `done_o` until the next acceptance |

## Verification
Each result is due a fixed number of cycles after acceptance: four edges for a word read, three for the other reads and for word and byte writes, two for a halfword write, N+1 for a clear of N halfwords, and one for a reject. The bench counts edges from the accepting edge up to the first falling-edge sample that shows `done_o`. It compares that count with the expected latency, and reads `rdata_o` and `err_o` at that same sample. Memory effects such as write order, byte preservation and clear extent are checked through later reads of the neighbouring halfwords.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  typedef enum logic [2:0] {
    OP_RD_W  = 3'd0,
    OP_RD_H  = 3'd1,
    OP_RD_B  = 3'd2,
    OP_RD_LO = 3'd3,
    OP_WR_W  = 3'd4,
    OP_WR_H  = 3'd5,
    OP_WR_B  = 3'd6,
    OP_CLR   = 3'd7
  } hwb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ISSUE,
    ST_RD_CAP,
    ST_RD_CAP2,
    ST_WR_HI,
    ST_WR_LO,
    ST_CLR,
    ST_DONE
  } hwb_st_e;
endpackage

// File: rtl/hwb_ram.sv
module hwb_ram #(
  parameter int HW_AW = 11
) (
  input  logic             clk_i,
  input  logic             re_i,
  input  logic             we_i,
  input  logic [HW_AW-1:0] addr_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o
);
  localparam int DEPTH = 2 ** HW_AW;

  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/hwb_align.sv
module hwb_align
  import hwb_pkg::*;
#(
  parameter int AW = 12
) (
  input  hwb_op_e       op_i,
  input  logic [AW-1:0] addr_i,
  output logic          misalign_o
);
  always_comb begin
    unique case (op_i)
      OP_RD_W, OP_RD_LO, OP_WR_W: misalign_o = |addr_i[1:0];
      OP_RD_H, OP_WR_H, OP_CLR:   misalign_o = addr_i[0];
      default:                    misalign_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hwb_ctrl.sv
module hwb_ctrl
  import hwb_pkg::*;
#(
  parameter int AW = 12,
  localparam int HW_AW = AW - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  hwb_op_e          op_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [AW:0]      len_i,
  input  logic             misalign_i,
  input  logic [15:0]      ram_rdata_i,
  output logic             ram_re_o,
  output logic             ram_we_o,
  output logic [HW_AW-1:0] ram_addr_o,
  output logic [15:0]      ram_wdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [31:0]      rdata_o
);
  hwb_st_e          st_q;
  hwb_op_e          op_q;
  logic [HW_AW-1:0] hw_q;
  logic             lane_q;
  logic [31:0]      wdata_q;
  logic [AW:0]      cnt_q;
  logic             err_q;
  logic [31:0]      rdata_q;
  logic [HW_AW-1:0] hw_next;

  assign hw_next = hw_q + HW_AW'(1);

  // memory side, decoded from state
  always_comb begin
    ram_re_o    = 1'b0;
    ram_we_o    = 1'b0;
    ram_addr_o  = hw_q;
    ram_wdata_o = '0;
    unique case (st_q)
      ST_RD_ISSUE: ram_re_o = 1'b1;
      ST_RD_CAP: begin
        if (op_q == OP_RD_W) begin
          ram_re_o   = 1'b1;
          ram_addr_o = hw_next;
        end else if (op_q == OP_WR_B) begin
          ram_we_o    = 1'b1;
          ram_wdata_o = lane_q ? {ram_rdata_i[15:8], wdata_q[7:0]}
                               : {wdata_q[7:0], ram_rdata_i[7:0]};
        end
      end
      ST_WR_HI: begin
        ram_we_o    = 1'b1;
        ram_wdata_o = wdata_q[31:16];
      end
      ST_WR_LO: begin
        ram_we_o    = 1'b1;
        ram_wdata_o = wdata_q[15:0];
      end
      ST_CLR: ram_we_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_RD_W;
      hw_q    <= '0;
      lane_q  <= 1'b0;
      wdata_q <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          op_q    <= op_i;
          lane_q  <= addr_i[0];
          wdata_q <= wdata_i;
          cnt_q   <= len_i >> 1;
          err_q   <= misalign_i;
          rdata_q <= '0;
          hw_q    <= addr_i[AW-1:1] + ((op_i == OP_RD_LO) ? HW_AW'(1) : HW_AW'(0));
          if (misalign_i) st_q <= ST_DONE;
          else begin
            unique case (op_i)
              OP_WR_W: st_q <= ST_WR_HI;
              OP_WR_H: st_q <= ST_WR_LO;
              OP_CLR:  st_q <= ((len_i >> 1) == '0) ? ST_DONE : ST_CLR;
              default: st_q <= ST_RD_ISSUE;
            endcase
          end
        end
        ST_RD_ISSUE: st_q <= ST_RD_CAP;
        ST_RD_CAP: begin
          unique case (op_q)
            OP_RD_W: begin
              rdata_q[31:16] <= ram_rdata_i;
              st_q           <= ST_RD_CAP2;
            end
            OP_RD_B: begin
              rdata_q <= {24'h0, lane_q ? ram_rdata_i[7:0] : ram_rdata_i[15:8]};
              st_q    <= ST_DONE;
            end
            OP_WR_B: st_q <= ST_DONE;
            default: begin
              rdata_q <= {16'h0, ram_rdata_i};
              st_q    <= ST_DONE;
            end
          endcase
        end
        ST_RD_CAP2: begin
          rdata_q[15:0] <= ram_rdata_i;
          st_q          <= ST_DONE;
        end
        ST_WR_HI: begin
          hw_q <= hw_next;
          st_q <= ST_WR_LO;
        end
        ST_WR_LO: st_q <= ST_DONE;
        ST_CLR: begin
          hw_q  <= hw_next;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == (AW+1)'(1)) st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = (st_q == ST_DONE);
  assign err_o   = done_o & err_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/hwb_bridge.sv
module hwb_bridge
  import hwb_pkg::*;
#(
  parameter int AW = 12,
  localparam int HW_AW = AW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW:0]   len_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [31:0]   rdata_o
);
  hwb_op_e          op;
  logic             misalign;
  logic             ram_re;
  logic             ram_we;
  logic [HW_AW-1:0] ram_addr;
  logic [15:0]      ram_wdata;
  logic [15:0]      ram_rdata;

  assign op = hwb_op_e'(op_i);

  hwb_align #(.AW(AW)) u_align (
    .op_i      (op),
    .addr_i    (addr_i),
    .misalign_o(misalign)
  );

  hwb_ctrl #(.AW(AW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .op_i       (op),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .len_i      (len_i),
    .misalign_i (misalign),
    .ram_rdata_i(ram_rdata),
    .ram_re_o   (ram_re),
    .ram_we_o   (ram_we),
    .ram_addr_o (ram_addr),
    .ram_wdata_o(ram_wdata),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .rdata_o    (rdata_o)
  );

  hwb_ram #(.HW_AW(HW_AW)) u_ram (
    .clk_i  (clk_i),
    .re_i   (ram_re),
    .we_i   (ram_we),
    .addr_i (ram_addr),
    .wdata_i(ram_wdata),
    .rdata_o(ram_rdata)
  );
endmodule

// File: rtl/hwb_bridge_chk.sv
module hwb_bridge_chk #(
  parameter int HW_AW = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ram_re,
  input logic             ram_we,
  input logic [HW_AW-1:0] ram_addr,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o
);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ram_we && !ram_re));

  p_err_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  p_err_nowrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!ram_we && !$past(ram_we)));

  p_seq_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we && $past(ram_we)) |-> (ram_addr == HW_AW'($past(ram_addr) + 1'b1)));

  p_rmw_same_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we && !$past(ram_we) && $past(ram_re)) |-> (ram_addr == $past(ram_addr)));
endmodule

bind hwb_bridge hwb_bridge_chk #(.HW_AW(HW_AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ram_re  (ram_re),
  .ram_we  (ram_we),
  .ram_addr(ram_addr),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o)
);

// File: tb/hwb_bridge_tb_top.sv
`timescale 1ns/1ps
module hwb_bridge_tb_top;
  localparam int AW = 12;

  typedef struct packed {
    logic [2:0]  op;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [12:0] len;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  lat;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{3'd4, 12'h010, 32'h11223344, 13'd0, 32'h0,        1'b0, 4'd3, 4'd2},  // R2
    '{3'd0, 12'h010, 32'h0,        13'd0, 32'h11223344, 1'b0, 4'd4, 4'd1},  // R1
    '{3'd1, 12'h010, 32'h0,        13'd0, 32'h00001122, 1'b0, 4'd3, 4'd5},  // R5
    '{3'd1, 12'h012, 32'h0,        13'd0, 32'h00003344, 1'b0, 4'd3, 4'd5},
    '{3'd2, 12'h010, 32'h0,        13'd0, 32'h00000011, 1'b0, 4'd3, 4'd3},  // R3
    '{3'd2, 12'h011, 32'h0,        13'd0, 32'h00000022, 1'b0, 4'd3, 4'd3},
    '{3'd2, 12'h013, 32'h0,        13'd0, 32'h00000044, 1'b0, 4'd3, 4'd3},
    '{3'd3, 12'h010, 32'h0,        13'd0, 32'h00003344, 1'b0, 4'd3, 4'd4},  // R4
    '{3'd6, 12'h011, 32'h000000AB, 13'd0, 32'h0,        1'b0, 4'd3, 4'd6},  // R6
    '{3'd1, 12'h010, 32'h0,        13'd0, 32'h000011AB, 1'b0, 4'd3, 4'd6},
    '{3'd6, 12'h012, 32'hFFFFFFCD, 13'd0, 32'h0,        1'b0, 4'd3, 4'd6},
    '{3'd1, 12'h012, 32'h0,        13'd0, 32'h0000CD44, 1'b0, 4'd3, 4'd6},
    '{3'd4, 12'h020, 32'hDEADBEEF, 13'd0, 32'h0,        1'b0, 4'd3, 4'd2},
    '{3'd5, 12'h022, 32'hFFFF5566, 13'd0, 32'h0,        1'b0, 4'd2, 4'd5},
    '{3'd0, 12'h020, 32'h0,        13'd0, 32'hDEAD5566, 1'b0, 4'd4, 4'd5},
    '{3'd0, 12'h012, 32'h0,        13'd0, 32'h0,        1'b1, 4'd1, 4'd8},  // R8
    '{3'd4, 12'h011, 32'hFFFFFFFF, 13'd0, 32'h0,        1'b1, 4'd1, 4'd8},
    '{3'd1, 12'h013, 32'h0,        13'd0, 32'h0,        1'b1, 4'd1, 4'd8},
    '{3'd3, 12'h002, 32'h0,        13'd0, 32'h0,        1'b1, 4'd1, 4'd8},
    '{3'd5, 12'h021, 32'h00000000, 13'd0, 32'h0,        1'b1, 4'd1, 4'd8},
    '{3'd7, 12'h005, 32'h0,        13'd4, 32'h0,        1'b1, 4'd1, 4'd8},
    '{3'd0, 12'h010, 32'h0,        13'd0, 32'h11ABCD44, 1'b0, 4'd4, 4'd8},
    '{3'd0, 12'h020, 32'h0,        13'd0, 32'hDEAD5566, 1'b0, 4'd4, 4'd8},
    '{3'd4, 12'h040, 32'hAAAABBBB, 13'd0, 32'h0,        1'b0, 4'd3, 4'd2},
    '{3'd4, 12'h044, 32'hCCCCDDDD, 13'd0, 32'h0,        1'b0, 4'd3, 4'd2},
    '{3'd4, 12'h048, 32'h12345678, 13'd0, 32'h0,        1'b0, 4'd3, 4'd2},
    '{3'd7, 12'h042, 32'h0,        13'd5, 32'h0,        1'b0, 4'd3, 4'd7},  // R7
    '{3'd0, 12'h040, 32'h0,        13'd0, 32'hAAAA0000, 1'b0, 4'd4, 4'd7},
    '{3'd0, 12'h044, 32'h0,        13'd0, 32'h0000DDDD, 1'b0, 4'd4, 4'd7},
    '{3'd0, 12'h048, 32'h0,        13'd0, 32'h12345678, 1'b0, 4'd4, 4'd7},
    '{3'd7, 12'h048, 32'h0,        13'd1, 32'h0,        1'b0, 4'd1, 4'd7},
    '{3'd0, 12'h048, 32'h0,        13'd0, 32'h12345678, 1'b0, 4'd4, 4'd7}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [2:0]    op = '0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [AW:0]   len = '0;
  logic          busy, done, err;
  logic [31:0]   rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hwb_bridge #(.AW(AW)) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req),
    .op_i   (op),
    .addr_i (addr),
    .wdata_i(wdata),
    .len_i  (len),
    .busy_o (busy),
    .done_o (done),
    .err_o  (err),
    .rdata_o(rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // raise a request at a falling edge, return latency and end at the done sample
  task automatic run_op(input logic [2:0] o, input logic [AW-1:0] a, input logic [31:0] d,
                        input logic [AW:0] l, output int lat);
    @(negedge clk);
    req = 1'b1; op = o; addr = a; wdata = d; len = l;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    string tg;
    repeat (3) @(negedge clk);
    // R11: outputs quiet during reset
    check(!busy && !done && !err, "R11 ctl in reset", {29'h0, busy, done, err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err, "R11 ctl after reset", {29'h0, busy, done, err}, 32'h0);
    check(rdata == 32'h0, "R11 rdata after reset", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i].op, VEC[i].addr, VEC[i].wdata, VEC[i].len, lat);
      tg = $sformatf("R%0d vec %0d", VEC[i].rq, i);
      check(rdata == VEC[i].exp, {tg, " rdata"}, rdata, VEC[i].exp);
      check(err == VEC[i].err, {tg, " err"}, {31'h0, err}, {31'h0, VEC[i].err});
      check(lat == int'(VEC[i].lat), $sformatf("R10 vec %0d latency", i), lat, VEC[i].lat);
      @(negedge clk);
      check(!done && !busy, $sformatf("R9 vec %0d done pulse", i), {30'h0, busy, done}, 32'h0);
    end

    // R9: a request while busy is ignored
    @(negedge clk);
    req = 1'b1; op = 3'd0; addr = 12'h040; wdata = '0; len = '0;
    @(negedge clk);
    check(busy, "R9 busy after accept", {31'h0, busy}, 32'h1);
    op = 3'd4; addr = 12'h040; wdata = 32'h0BAD0BAD;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    req = 1'b0;
    check(rdata == 32'hAAAA0000, "R9 read under busy req", rdata, 32'hAAAA0000);
    run_op(3'd0, 12'h040, 32'h0, '0, lat);
    check(rdata == 32'hAAAA0000, "R9 ignored write left memory", rdata, 32'hAAAA0000);

    // R7: clear across a word boundary leaves the next halfword intact
    run_op(3'd4, 12'h060, 32'h01020304, '0, lat);
    run_op(3'd4, 12'h064, 32'h05060708, '0, lat);
    run_op(3'd7, 12'h060, 32'h0, 13'd6, lat);
    check(lat == 4, "R10 clear of 3 latency", lat, 4);
    run_op(3'd0, 12'h064, 32'h0, '0, lat);
    check(rdata == 32'h00000708, "R7 clear extent", rdata, 32'h00000708);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule